// File: doc/BRIEF.md
# Segmented FPU Result Writeback Pipeline

This block moves a floating-point result of up to 80 bits through the back half of a 32-bit integer pipeline (execute, memory access, writeback) and commits it to a floating-point register file built from 32-bit registers. The instruction's precision class and its destination index enter at execute. A decoder turns them into per-word write controls, and those controls travel with the instruction one stage per cycle.

The FPU output bus is consumed one 32-bit word per stage. Execute takes bits 31:0. Memory access takes bits 63:32 while the same instruction sits there. Writeback takes bits 79:64, zero-extended to 32 bits. The FPU must therefore present each slice of a result during the cycle that its instruction occupies the stage that consumes the slice. Writeback then drives up to three register file write ports for a single cycle.

A global stall freezes every stage and blocks the write. A flush drops the instructions in execute and memory access. A misaligned destination for a multi-word class raises an error pulse in place of the write.

Top module: `fpu_seg_wb`

## Requirements
- R1: The class code `ex_cls_i` is decoded as follows: 2'b00 is no FP write, 2'b01 is single, 2'b10 is double and 2'b11 is ultra. The resulting `rf_we_o` is 3'b000, 3'b001, 3'b011 and 3'b111 respectively, with bit k enabling write port k.
- R2: Write port k carries address rd+k, where rd is the destination index given at execute.
- R3: Port 0 data is `fpu_res_i[31:0]` as seen at the clock edge that ends the instruction's execute cycle. Port 1 data is `fpu_res_i[63:32]` at the edge that ends its memory access cycle. Port 2 data is {16'b0, `fpu_res_i[79:64]`} at the edge that ends its writeback cycle. An edge counts only when no stall is present at it.
- R4: Any data word that the instruction's class does not use reads as zero on `rf_wdata_o`.
- R5: With no stall, the write enables of an instruction presented at execute go high after the third rising edge from that point. They stay high for exactly one cycle. No write appears without an instruction behind it.
- R6: A double-class rd with bit 0 set, or an ultra-class rd with bits 1:0 not both zero, produces no write. Instead it pulses `rf_err_o` for one cycle at the time the write would have occurred.
- R7: While `stall_i` is high at an edge, no stage advances, `rf_we_o` and `rf_err_o` are low after that edge, and a frozen instruction commits intact once the stall is released.
- R8: A flush at an edge with no stall discards the instructions in execute and memory access, which never write. The instruction in writeback still commits. While a stall is present, flush has no effect.
- R9: While `rst_ni` is low, all valid bits, stored words and outputs are cleared.
- R10: A new instruction may enter on every cycle, and each one commits in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global pipeline stall |
| flush_i | input | 1 | Discard execute and memory access instructions |
| ex_valid_i | input | 1 | Instruction present in execute |
| ex_cls_i | input | 2 | Precision class of the execute instruction |
| ex_rd_i | input | 5 | Destination register index |
| fpu_res_i | input | 80 | FPU output bus, one slice consumed per stage |
| rf_we_o | output | 3 | Per-port register file write enables |
| rf_waddr_o | output | 15 | Three 5-bit write addresses, port k at bits 5k+4:5k |
| rf_wdata_o | output | 96 | Three 32-bit write words, port k at bits 32k+31:32k |
| rf_err_o | output | 1 | Misaligned destination pulse |

## Verification
A result is due after the third unstalled rising edge following its execute cycle. Each stalled edge pushes it back by one. The driver advances its own stage model at every edge it drives. It records the bus slice each stage would take and files the expected write under the exact edge count at which it must appear. The monitor samples at the falling edge after each rising edge and compares whatever is due in that cycle. In every other cycle it requires the enables and the error pulse to be low, so an early, late or duplicated write is caught as well as a wrong one.

// File: rtl/fpu_seg_pkg.sv
package fpu_seg_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned RES_W  = 80;
  parameter int unsigned REG_N  = 32;
  localparam int unsigned SEG_N  = 3;
  localparam int unsigned REG_AW = $clog2(REG_N);
  localparam int unsigned EXT_W  = SEG_N * WORD_W;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_SGL  = 2'b01,
    CLS_DBL  = 2'b10,
    CLS_ULT  = 2'b11
  } fp_cls_e;

  typedef struct packed {
    logic                          valid;
    logic [REG_AW-1:0]             rd;
    logic [SEG_N-1:0]              need;
    logic                          misal;
    logic [SEG_N-1:0][WORD_W-1:0]  word;
  } seg_ctl_t;
endpackage

// File: rtl/fpu_seg_decode.sv
module fpu_seg_decode
  import fpu_seg_pkg::*;
(
  input  logic              valid_i,
  input  fp_cls_e           cls_i,
  input  logic [REG_AW-1:0] rd_i,
  output seg_ctl_t          ctl_o
);
  always_comb begin
    ctl_o       = '0;
    ctl_o.valid = valid_i;
    ctl_o.rd    = rd_i;
    unique case (cls_i)
      CLS_SGL: ctl_o.need = 3'b001;
      CLS_DBL: begin
        ctl_o.need  = 3'b011;
        ctl_o.misal = rd_i[0];
      end
      CLS_ULT: begin
        ctl_o.need  = 3'b111;
        ctl_o.misal = |rd_i[1:0];
      end
      default: ctl_o.need = 3'b000;
    endcase
  end
endmodule

// File: rtl/fpu_seg_stage.sv
module fpu_seg_stage
  import fpu_seg_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              kill_i,
  input  seg_ctl_t          d_i,
  input  logic [WORD_W-1:0] slice_i,
  output seg_ctl_t          q_o
);
  seg_ctl_t nxt;

  always_comb begin
    nxt           = d_i;
    nxt.valid     = d_i.valid & ~kill_i;
    nxt.word[IDX] = (d_i.valid && d_i.need[IDX]) ? slice_i : d_i.word[IDX];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= nxt;
  end

  assert_hold_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(q_o));
  assert_kill_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && kill_i) |=> !q_o.valid);
  assert_unused_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.valid && !q_o.need[IDX]) |-> (q_o.word[IDX] == '0));
endmodule

// File: rtl/fpu_seg_commit.sv
module fpu_seg_commit
  import fpu_seg_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hold_i,
  input  seg_ctl_t                     d_i,
  input  logic [WORD_W-1:0]            slice_i,
  output logic [SEG_N-1:0]             we_o,
  output logic [SEG_N-1:0][REG_AW-1:0] waddr_o,
  output logic [SEG_N-1:0][WORD_W-1:0] wdata_o,
  output logic                         err_o
);
  localparam int unsigned LAST = SEG_N - 1;

  logic [SEG_N-1:0]             we_n;
  logic                         err_n;
  logic [SEG_N-1:0][REG_AW-1:0] addr_n;
  logic [SEG_N-1:0][WORD_W-1:0] data_n;

  always_comb begin
    we_n  = (d_i.valid && !d_i.misal && !hold_i) ? d_i.need : '0;
    err_n = d_i.valid && d_i.misal && !hold_i;
    data_n       = d_i.word;
    data_n[LAST] = (d_i.valid && d_i.need[LAST]) ? slice_i : d_i.word[LAST];
  end

  for (genvar k = 0; k < SEG_N; k++) begin : g_addr
    assign addr_n[k] = d_i.rd + REG_AW'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= '0;
      err_o   <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o  <= we_n;
      err_o <= err_n;
      if (!hold_i) begin
        waddr_o <= addr_n;
        wdata_o <= data_n;
      end
    end
  end

  assert_we_contig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o[2] |-> we_o[1]) and (we_o[1] |-> we_o[0]));
  assert_err_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (we_o == '0));
  assert_dbl_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o[1] |-> !waddr_o[0][0]);
  assert_ult_quad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o[2] |-> (waddr_o[0][1:0] == 2'b00));
  assert_stall_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (we_o == '0 && !err_o));
  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o[1] |-> (waddr_o[1] == waddr_o[0] + REG_AW'(1)));
endmodule

// File: rtl/fpu_seg_wb.sv
module fpu_seg_wb
  import fpu_seg_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         stall_i,
  input  logic                         flush_i,
  input  logic                         ex_valid_i,
  input  logic [1:0]                   ex_cls_i,
  input  logic [REG_AW-1:0]            ex_rd_i,
  input  logic [RES_W-1:0]             fpu_res_i,
  output logic [SEG_N-1:0]             rf_we_o,
  output logic [SEG_N-1:0][REG_AW-1:0] rf_waddr_o,
  output logic [SEG_N-1:0][WORD_W-1:0] rf_wdata_o,
  output logic                         rf_err_o
);
  logic [EXT_W-1:0] res_ext;
  seg_ctl_t ex_ctl, ma_q, wb_q;

  assign res_ext = EXT_W'(fpu_res_i);

  fpu_seg_decode u_dec (
    .valid_i (ex_valid_i),
    .cls_i   (fp_cls_e'(ex_cls_i)),
    .rd_i    (ex_rd_i),
    .ctl_o   (ex_ctl)
  );

  // execute -> memory access register takes word 0
  fpu_seg_stage #(.IDX(0)) u_ma (
    .clk_i, .rst_ni,
    .hold_i  (stall_i),
    .kill_i  (flush_i),
    .d_i     (ex_ctl),
    .slice_i (res_ext[0 +: WORD_W]),
    .q_o     (ma_q)
  );

  // memory access -> writeback register takes word 1
  fpu_seg_stage #(.IDX(1)) u_wb (
    .clk_i, .rst_ni,
    .hold_i  (stall_i),
    .kill_i  (flush_i),
    .d_i     (ma_q),
    .slice_i (res_ext[WORD_W +: WORD_W]),
    .q_o     (wb_q)
  );

  // writeback takes word 2 and drives the register file
  fpu_seg_commit u_cmt (
    .clk_i, .rst_ni,
    .hold_i  (stall_i),
    .d_i     (wb_q),
    .slice_i (res_ext[2*WORD_W +: WORD_W]),
    .we_o    (rf_we_o),
    .waddr_o (rf_waddr_o),
    .wdata_o (rf_wdata_o),
    .err_o   (rf_err_o)
  );
endmodule

// File: tb/sim_fpu_seg_wb.sv
`timescale 1ns/1ps
module sim_fpu_seg_wb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stall_i = 1'b0, flush_i = 1'b0, ex_valid_i = 1'b0;
  logic [1:0] ex_cls_i = 2'b00;
  logic [4:0] ex_rd_i = '0;
  logic [79:0] fpu_res_i = '0;
  logic [2:0] rf_we_o;
  logic [2:0][4:0] rf_waddr_o;
  logic [2:0][31:0] rf_wdata_o;
  logic rf_err_o;

  fpu_seg_wb u0 (.clk_i(clk), .*);

  always #10 clk = ~clk;

  typedef struct { logic v; logic [1:0] c; logic [4:0] rd; logic [31:0] w0, w1; } slot_t;
  typedef struct { int due; logic [2:0] we; logic err; logic [4:0] rd; logic [31:0] w0, w1, w2; } exp_t;

  exp_t  q[$];
  slot_t ma_s, wb_s;
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 0, done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [2:0] need_of(input logic [1:0] c);
    case (c)
      2'b01: return 3'b001;
      2'b10: return 3'b011;
      2'b11: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic misal_of(input logic [1:0] c, input logic [4:0] rd);
    return (c == 2'b10 && rd[0]) || (c == 2'b11 && rd[1:0] != 2'b00);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and advances the stage model
  task automatic step(input logic v, input logic [1:0] c, input logic [4:0] rd,
                      input logic st, input logic fl);
    logic [2:0] nd;
    exp_t e;
    @(negedge clk);
    ex_valid_i = v; ex_cls_i = c; ex_rd_i = rd; stall_i = st; flush_i = fl;
    fpu_res_i = {16'($urandom), $urandom, $urandom};
    if (!st) begin
      if (wb_s.v) begin
        nd = need_of(wb_s.c);
        e = '{due: cyc + 1, we: 3'b000, err: 1'b0, rd: wb_s.rd, w0: wb_s.w0, w1: wb_s.w1,
              w2: nd[2] ? {16'h0, fpu_res_i[79:64]} : 32'h0};
        if (misal_of(wb_s.c, wb_s.rd)) begin e.err = 1'b1; q.push_back(e); end
        else if (nd != 3'b000) begin e.we = nd; q.push_back(e); end
      end
      wb_s = ma_s;
      wb_s.w1 = (ma_s.v && need_of(ma_s.c)[1]) ? fpu_res_i[63:32] : 32'h0;
      if (fl) wb_s.v = 1'b0;
      ma_s = '{v: v && !fl, c: c, rd: rd,
               w0: (v && need_of(c)[0]) ? fpu_res_i[31:0] : 32'h0, w1: 32'h0};
    end
  endtask

  // monitor: compares whatever write is due in this cycle, else requires silence
  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].due < cyc) begin
        chk(0, "R5 missing write", 32'(q[0].rd), 32'(q[0].due));
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(rf_we_o == e.we, "R1 write enables", 32'(rf_we_o), 32'(e.we));
        chk(rf_err_o == e.err, "R6 error pulse", 32'(rf_err_o), 32'(e.err));
        if (!e.err) begin
          for (int k = 0; k < 3; k++)
            if (e.we[k]) chk(rf_waddr_o[k] == e.rd + 5'(k), "R2 address", 32'(rf_waddr_o[k]), 32'(e.rd + 5'(k)));
          chk(rf_wdata_o[0] == e.w0, "R3 word0", rf_wdata_o[0], e.w0);
          chk(rf_wdata_o[1] == e.w1, e.we[1] ? "R3 word1" : "R4 unused word1", rf_wdata_o[1], e.w1);
          chk(rf_wdata_o[2] == e.w2, e.we[2] ? "R3 word2" : "R4 unused word2", rf_wdata_o[2], e.w2);
        end
      end else begin
        chk(rf_we_o == 3'b000 && !rf_err_o, "R5 no spurious write",
            {28'h0, rf_err_o, rf_we_o}, 32'h0);
      end
    end
  end

  function automatic logic [4:0] rand_rd(input logic [1:0] c, input bit bad);
    logic [4:0] r;
    r = 5'($urandom);
    if (!bad) begin
      if (c == 2'b10) r[0] = 1'b0;
      if (c == 2'b11) r[1:0] = 2'b00;
    end
    return r;
  endfunction

  initial begin
    ma_s = '{v: 0, c: 0, rd: 0, w0: 0, w1: 0};
    wb_s = ma_s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9: cleared state after reset
    chk(rf_we_o == 3'b000 && !rf_err_o, "R9 reset enables", {28'h0, rf_err_o, rf_we_o}, 32'h0);
    chk(rf_wdata_o == '0, "R9 reset data", rf_wdata_o[0], 32'h0);
    chk(rf_waddr_o == '0, "R9 reset addr", 32'(rf_waddr_o), 32'h0);
    mon_on = 1;
    // R1 R2 R3 R4 R5: one of each class, spaced out
    step(1, 2'b01, 5'd5, 0, 0);  step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(1, 2'b10, 5'd6, 0, 0);  step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(1, 2'b11, 5'd28, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(1, 2'b00, 5'd3, 0, 0);  step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    // R6: misaligned destinations, then aligned edge cases
    step(1, 2'b10, 5'd7, 0, 0);  step(1, 2'b11, 5'd10, 0, 0); step(1, 2'b11, 5'd29, 0, 0);
    step(1, 2'b10, 5'd30, 0, 0); step(1, 2'b01, 5'd31, 0, 0);
    // R10: back-to-back mix
    for (int i = 0; i < 12; i++) begin
      logic [1:0] c;
      c = 2'($urandom);
      step(1, c, rand_rd(c, 0), 0, 0);
    end
    // R7: stall with a full pipeline
    step(1, 2'b11, 5'd4, 0, 0); step(1, 2'b10, 5'd2, 0, 0); step(1, 2'b01, 5'd9, 0, 0);
    step(1, 2'b11, 5'd8, 1, 0); step(1, 2'b01, 5'd1, 1, 0); step(1, 2'b10, 5'd0, 1, 0);
    step(1, 2'b01, 5'd11, 0, 0);
    // R8: flush with a full pipeline, then flush ignored under stall
    step(1, 2'b11, 5'd12, 0, 0); step(1, 2'b10, 5'd14, 0, 0); step(1, 2'b01, 5'd15, 0, 0);
    step(1, 2'b11, 5'd16, 0, 1); step(0, 0, 0, 0, 0);
    step(1, 2'b11, 5'd20, 0, 0); step(1, 2'b10, 5'd22, 0, 0); step(1, 2'b01, 5'd23, 1, 1);
    step(0, 0, 0, 0, 0);
    // random mix of everything
    for (int i = 0; i < 300; i++) begin
      logic [1:0] c;
      c = 2'($urandom);
      step(($urandom % 4) != 0, c, rand_rd(c, ($urandom % 6) == 0),
           ($urandom % 8) == 0, ($urandom % 10) == 0);
    end
    repeat (6) step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(q.size() == 0, "R5 drained", 32'(q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule